// File: doc/BRIEF.md
# Arc Voxel Stepper

The block traces a circular arc through an integer voxel grid and emits it one voxel at a time. A caller gives the arc's centre voxel, a start voxel, an end voxel, an integer normal of the arc's plane, the squared radius, a weight for the plane term and a step budget. A one-cycle go strobe starts the walk. The start voxel comes out first. Each later voxel is the best of seven neighbours of the current voxel. The walk ends when the end voxel has been accepted, or with an overrun flag when the step budget runs out first.

The neighbours lie in the octant of the local tangent, which is the cross product of the normal with the offset from the centre. Each neighbour is scored with integer arithmetic only. The score adds the radius mismatch to the weighted distance from the plane, and the lowest score wins. Equal scores are settled by a fixed priority order. Voxels leave on a valid/ready stream, so a downstream writer can stall the walk at any point without losing a voxel.

Top module: `arc_voxel_walker`

## Requirements
- R1: A go pulse while idle latches all set-up inputs. In the next cycle `vox_valid` is high and the output carries the start voxel.
- R2: The seven candidates are the current voxel plus unit steps whose per-axis signs follow the tangent `t = n × (V − C)`. A zero tangent component counts as positive. The candidates are tried in priority index order 0..6, with axis masks (x,y,z) 100, 010, 001, 110, 101, 011, 111.
- R3: A candidate's score is `|d·d − R²| + W·|n·d|`, where `d` is the candidate minus the centre. The next voxel is the candidate with the smallest score.
- R4: When scores are equal, the candidate with the lower priority index wins.
- R5: Each emitted voxel differs from the one before it by at most one on every axis and is never equal to it.
- R6: Once the end voxel has been accepted, `busy` drops and `done` rises, and both hold until the next go. The start and end voxels are both emitted. If the start equals the end, exactly one voxel is emitted.
- R7: If the end voxel has not been accepted after `step_limit` moves, the walk stops after step_limit+1 voxels, with both `done` and `overrun` high.
- R8: While `vox_valid` is high and `vox_ready` is low, the voxel holds steady and the walk does not advance.
- R9: After a non-final voxel is accepted, `vox_valid` stays low for exactly two cycles. In the third cycle the next voxel is valid.
- R10: A go pulse while `busy` is high is ignored, and the walk in progress goes on unchanged.
- R11: After reset, `vox_valid`, `busy`, `done` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arc_go | input | 1 | Start strobe, used only while idle |
| centre_x | input | CW | Arc centre, x (signed) |
| centre_y | input | CW | Arc centre, y (signed) |
| centre_z | input | CW | Arc centre, z (signed) |
| first_x | input | CW | Start voxel, x (signed) |
| first_y | input | CW | Start voxel, y (signed) |
| first_z | input | CW | Start voxel, z (signed) |
| last_x | input | CW | End voxel, x (signed) |
| last_y | input | CW | End voxel, y (signed) |
| last_z | input | CW | End voxel, z (signed) |
| norm_x | input | NW | Plane normal, x (signed) |
| norm_y | input | NW | Plane normal, y (signed) |
| norm_z | input | NW | Plane normal, z (signed) |
| radius_sq | input | 2*CW+2 | Squared radius |
| plane_weight | input | WW | Weight applied to the plane term |
| step_limit | input | LW | Maximum number of moves |
| vox_ready | input | 1 | Downstream accepts the voxel |
| vox_valid | output | 1 | Output voxel valid |
| vox_x | output | CW | Output voxel, x (signed) |
| vox_y | output | CW | Output voxel, y (signed) |
| vox_z | output | CW | Output voxel, z (signed) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished |
| overrun | output | 1 | Walk stopped by the step budget |

## Verification
A wrong score, sign or tie choice changes the next voxel. That shows at the ports on the first valid cycle after the two-cycle gap, and every later voxel then differs from the reference walk. A control-state fault shows in the same clock as a wrong `vox_valid`, `busy` or `done`, so the bench compares every output against its reference on every clock. An error in the latching of set-up inputs, or in go filtering, shows as a wrong path or a wrong end flag at the end of the run.

// File: rtl/avw_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the arc voxel stepper.
// Assumes seven candidates per step, listed in fixed priority order.
package avw_pkg;
    localparam int CAND_N = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_SCORE = 2'd2,
        ST_PICK  = 2'd3
    } avw_state_e;

    // Axis mask {x,y,z} for each priority index: single-axis, two-axis, diagonal.
    function automatic logic [2:0] cand_mask(input int idx);
        case (idx)
            0:       return 3'b100;
            1:       return 3'b010;
            2:       return 3'b001;
            3:       return 3'b110;
            4:       return 3'b101;
            5:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction
endpackage

// File: rtl/avw_cand_gen.sv
`timescale 1ns/1ps
// Candidate generator: forms seven unit-step neighbours of the current voxel.
// The step signs come from the tangent n x (cur - centre), and zero counts
// as positive. Purely combinational; assumes the coordinates do not wrap.
module avw_cand_gen
    import avw_pkg::*;
#(
    parameter int CW = 12,
    parameter int NW = 8
) (
    input  logic signed [CW-1:0] cur_x,
    input  logic signed [CW-1:0] cur_y,
    input  logic signed [CW-1:0] cur_z,
    input  logic signed [CW-1:0] cen_x,
    input  logic signed [CW-1:0] cen_y,
    input  logic signed [CW-1:0] cen_z,
    input  logic signed [NW-1:0] nrm_x,
    input  logic signed [NW-1:0] nrm_y,
    input  logic signed [NW-1:0] nrm_z,
    output logic signed [CW-1:0] cand_x [CAND_N],
    output logic signed [CW-1:0] cand_y [CAND_N],
    output logic signed [CW-1:0] cand_z [CAND_N]
);
    localparam int TW = CW + NW + 3;
    localparam logic signed [CW-1:0] ONE = 1;

    logic signed [TW-1:0] dx, dy, dz, tx, ty, tz;
    logic neg_x, neg_y, neg_z;

    // Offset from the centre and tangent cross product.
    always_comb begin
        dx = TW'(cur_x) - TW'(cen_x);
        dy = TW'(cur_y) - TW'(cen_y);
        dz = TW'(cur_z) - TW'(cen_z);
        tx = TW'(nrm_y) * dz - TW'(nrm_z) * dy;
        ty = TW'(nrm_z) * dx - TW'(nrm_x) * dz;
        tz = TW'(nrm_x) * dy - TW'(nrm_y) * dx;
        neg_x = (tx < 0);
        neg_y = (ty < 0);
        neg_z = (tz < 0);
    end

    for (genvar k = 0; k < CAND_N; k++) begin : g_cand
        localparam logic [2:0] M = cand_mask(k);
        // Apply the masked unit step on each axis.
        always_comb begin
            cand_x[k] = M[2] ? (neg_x ? cur_x - ONE : cur_x + ONE) : cur_x;
            cand_y[k] = M[1] ? (neg_y ? cur_y - ONE : cur_y + ONE) : cur_y;
            cand_z[k] = M[0] ? (neg_z ? cur_z - ONE : cur_z + ONE) : cur_z;
        end
    end
endmodule

// File: rtl/avw_scorer.sv
`timescale 1ns/1ps
// Scorer: integer error of one candidate, |d.d - R^2| + W*|n.d|.
// SCW must be wide enough that neither term can overflow.
module avw_scorer #(
    parameter int CW  = 12,
    parameter int NW  = 8,
    parameter int WW  = 8,
    parameter int SQW = 2 * CW + 2,
    parameter int SCW = 2 * CW + NW + WW + 8
) (
    input  logic signed [CW-1:0]  cand_x,
    input  logic signed [CW-1:0]  cand_y,
    input  logic signed [CW-1:0]  cand_z,
    input  logic signed [CW-1:0]  cen_x,
    input  logic signed [CW-1:0]  cen_y,
    input  logic signed [CW-1:0]  cen_z,
    input  logic signed [NW-1:0]  nrm_x,
    input  logic signed [NW-1:0]  nrm_y,
    input  logic signed [NW-1:0]  nrm_z,
    input  logic [SQW-1:0]        rad_sq,
    input  logic [WW-1:0]         weight,
    output logic [SCW-1:0]        score
);
    logic signed [SCW-1:0] dx, dy, dz, mag, rerr, rabs, pdot, pabs, wext, rsq;

    // Radius term plus weighted plane term.
    always_comb begin
        dx   = SCW'(cand_x) - SCW'(cen_x);
        dy   = SCW'(cand_y) - SCW'(cen_y);
        dz   = SCW'(cand_z) - SCW'(cen_z);
        rsq  = $signed({{(SCW-SQW){1'b0}}, rad_sq});
        wext = $signed({{(SCW-WW){1'b0}}, weight});
        mag  = dx * dx + dy * dy + dz * dz;
        rerr = mag - rsq;
        rabs = (rerr < 0) ? -rerr : rerr;
        pdot = SCW'(nrm_x) * dx + SCW'(nrm_y) * dy + SCW'(nrm_z) * dz;
        pabs = (pdot < 0) ? -pdot : pdot;
        score = rabs + pabs * wext;
    end
endmodule

// File: rtl/avw_min_pick.sv
`timescale 1ns/1ps
// Minimum picker: index of the smallest score. The scan runs in priority
// order with a strict compare, so the lowest index wins a tie.
module avw_min_pick #(
    parameter int SCW = 48,
    parameter int N   = 7,
    localparam int IW = $clog2(N)
) (
    input  logic [SCW-1:0] scores [N],
    output logic [IW-1:0]  win
);
    logic [SCW-1:0] best;

    // Priority scan for the first minimum.
    always_comb begin
        best = scores[0];
        win  = '0;
        for (int k = 1; k < N; k++) begin
            if (scores[k] < best) begin
                best = scores[k];
                win  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/arc_voxel_walker.sv
`timescale 1ns/1ps
// Arc voxel stepper top. It latches the set-up on go and emits the start
// voxel. For every accepted non-final voxel it spends one cycle registering
// the seven scores and one cycle registering the winner, then emits it.
// Assumes set-up values are integers already rounded by the caller.
module arc_voxel_walker
    import avw_pkg::*;
#(
    parameter int CW = 12,
    parameter int NW = 8,
    parameter int WW = 8,
    parameter int LW = 16,
    localparam int SQW = 2 * CW + 2,
    localparam int SCW = 2 * CW + NW + WW + 8,
    localparam int IW  = $clog2(CAND_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arc_go,
    input  logic signed [CW-1:0] centre_x,
    input  logic signed [CW-1:0] centre_y,
    input  logic signed [CW-1:0] centre_z,
    input  logic signed [CW-1:0] first_x,
    input  logic signed [CW-1:0] first_y,
    input  logic signed [CW-1:0] first_z,
    input  logic signed [CW-1:0] last_x,
    input  logic signed [CW-1:0] last_y,
    input  logic signed [CW-1:0] last_z,
    input  logic signed [NW-1:0] norm_x,
    input  logic signed [NW-1:0] norm_y,
    input  logic signed [NW-1:0] norm_z,
    input  logic [SQW-1:0]       radius_sq,
    input  logic [WW-1:0]        plane_weight,
    input  logic [LW-1:0]        step_limit,
    input  logic                 vox_ready,
    output logic                 vox_valid,
    output logic signed [CW-1:0] vox_x,
    output logic signed [CW-1:0] vox_y,
    output logic signed [CW-1:0] vox_z,
    output logic                 busy,
    output logic                 done,
    output logic                 overrun
);
    avw_state_e state;
    logic signed [CW-1:0] cur_x, cur_y, cur_z;
    logic signed [CW-1:0] cen_x, cen_y, cen_z, fin_x, fin_y, fin_z;
    logic signed [NW-1:0] nrm_x, nrm_y, nrm_z;
    logic [SQW-1:0] rsq_q;
    logic [WW-1:0]  wgt_q;
    logic [LW-1:0]  lim_q, steps;
    logic done_q, ovr_q;

    logic signed [CW-1:0] cand_x [CAND_N];
    logic signed [CW-1:0] cand_y [CAND_N];
    logic signed [CW-1:0] cand_z [CAND_N];
    logic signed [CW-1:0] cq_x [CAND_N];
    logic signed [CW-1:0] cq_y [CAND_N];
    logic signed [CW-1:0] cq_z [CAND_N];
    logic [SCW-1:0] score [CAND_N];
    logic [SCW-1:0] score_q [CAND_N];
    logic [IW-1:0]  pick_idx;
    logic at_end;

    avw_cand_gen #(.CW(CW), .NW(NW)) u_gen (
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .cen_x(cen_x), .cen_y(cen_y), .cen_z(cen_z),
        .nrm_x(nrm_x), .nrm_y(nrm_y), .nrm_z(nrm_z),
        .cand_x(cand_x), .cand_y(cand_y), .cand_z(cand_z)
    );

    for (genvar k = 0; k < CAND_N; k++) begin : g_score
        avw_scorer #(.CW(CW), .NW(NW), .WW(WW), .SQW(SQW), .SCW(SCW)) u_sc (
            .cand_x(cand_x[k]), .cand_y(cand_y[k]), .cand_z(cand_z[k]),
            .cen_x(cen_x), .cen_y(cen_y), .cen_z(cen_z),
            .nrm_x(nrm_x), .nrm_y(nrm_y), .nrm_z(nrm_z),
            .rad_sq(rsq_q), .weight(wgt_q), .score(score[k])
        );
    end

    avw_min_pick #(.SCW(SCW), .N(CAND_N)) u_pick (
        .scores(score_q),
        .win(pick_idx)
    );

    // The current voxel is the end voxel.
    assign at_end = (cur_x == fin_x) && (cur_y == fin_y) && (cur_z == fin_z);

    // Walk control, set-up latch and stepping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            steps  <= '0;
            cur_x <= '0; cur_y <= '0; cur_z <= '0;
            cen_x <= '0; cen_y <= '0; cen_z <= '0;
            fin_x <= '0; fin_y <= '0; fin_z <= '0;
            nrm_x <= '0; nrm_y <= '0; nrm_z <= '0;
            rsq_q <= '0; wgt_q <= '0; lim_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (arc_go) begin
                    cur_x <= first_x; cur_y <= first_y; cur_z <= first_z;
                    cen_x <= centre_x; cen_y <= centre_y; cen_z <= centre_z;
                    fin_x <= last_x; fin_y <= last_y; fin_z <= last_z;
                    nrm_x <= norm_x; nrm_y <= norm_y; nrm_z <= norm_z;
                    rsq_q <= radius_sq;
                    wgt_q <= plane_weight;
                    lim_q <= step_limit;
                    steps <= '0;
                    done_q <= 1'b0;
                    ovr_q  <= 1'b0;
                    state  <= ST_EMIT;
                end
                ST_EMIT: if (vox_ready) begin
                    if (at_end) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (steps == lim_q) begin
                        done_q <= 1'b1;
                        ovr_q  <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_SCORE;
                    end
                end
                ST_SCORE: state <= ST_PICK;
                default: begin
                    cur_x <= cq_x[pick_idx];
                    cur_y <= cq_y[pick_idx];
                    cur_z <= cq_z[pick_idx];
                    steps <= steps + LW'(1);
                    state <= ST_EMIT;
                end
            endcase
        end
    end

    // Capture candidates and their scores for the pick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < CAND_N; k++) begin
                score_q[k] <= '0;
                cq_x[k] <= '0; cq_y[k] <= '0; cq_z[k] <= '0;
            end
        end else if (state == ST_SCORE) begin
            for (int k = 0; k < CAND_N; k++) begin
                score_q[k] <= score[k];
                cq_x[k] <= cand_x[k]; cq_y[k] <= cand_y[k]; cq_z[k] <= cand_z[k];
            end
        end
    end

    assign vox_valid = (state == ST_EMIT);
    assign vox_x     = cur_x;
    assign vox_y     = cur_y;
    assign vox_z     = cur_z;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign overrun   = ovr_q;

    // Two coordinates differ by at most one.
    function automatic logic near1(input logic signed [CW-1:0] a, input logic signed [CW-1:0] b);
        logic signed [CW:0] d;
        d = {a[CW-1], a} - {b[CW-1], b};
        return (d == (CW+1)'(0)) || (d == (CW+1)'(1)) || (d == -(CW+1)'(1));
    endfunction

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vox_valid && !vox_ready |=> vox_valid && $stable(vox_x) && $stable(vox_y) && $stable(vox_z));

    assert_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PICK |=> near1(cur_x, $past(cur_x)) && near1(cur_y, $past(cur_y))
            && near1(cur_z, $past(cur_z))
            && !(cur_x == $past(cur_x) && cur_y == $past(cur_y) && cur_z == $past(cur_z)));

    assert_ignore_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && arc_go |=> $stable(fin_x) && $stable(fin_y) && $stable(fin_z) && $stable(cen_x));

    assert_end_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> overrun || ($past(at_end) && !busy));

    for (genvar k = 0; k < CAND_N; k++) begin : g_chk
        assert_minimum_R3: assert property (@(posedge clk) disable iff (!rst_n)
            state == ST_PICK |-> score_q[pick_idx] <= score_q[k]);
        assert_tie_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
            state == ST_PICK && score_q[k] == score_q[pick_idx] |-> IW'(k) >= pick_idx);
    end
endmodule

// File: tb/arc_voxel_walker_tb.sv
`timescale 1ns/1ps
module arc_voxel_walker_tb;
    localparam int CW = 12, NW = 8, WW = 8, LW = 16;
    localparam int SQW = 2 * CW + 2;

    typedef struct {
        int cx, cy, cz, bx, by, bz, fx, fy, fz, nx, ny, nz;
        longint r2;
        int w, lim;
    } arc_t;

    logic clk = 0, rst_n = 0, arc_go = 0, vox_ready = 0;
    logic signed [CW-1:0] centre_x = 0, centre_y = 0, centre_z = 0;
    logic signed [CW-1:0] first_x = 0, first_y = 0, first_z = 0;
    logic signed [CW-1:0] last_x = 0, last_y = 0, last_z = 0;
    logic signed [NW-1:0] norm_x = 0, norm_y = 0, norm_z = 0;
    logic [SQW-1:0] radius_sq = 0;
    logic [WW-1:0] plane_weight = 0;
    logic [LW-1:0] step_limit = 0;
    logic vox_valid, busy, done, overrun;
    logic signed [CW-1:0] vox_x, vox_y, vox_z;

    arc_voxel_walker #(.CW(CW), .NW(NW), .WW(WW), .LW(LW)) u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int mk_x[7] = '{1, 0, 0, 1, 1, 0, 1};
    int mk_y[7] = '{0, 1, 0, 1, 0, 1, 1};
    int mk_z[7] = '{0, 0, 1, 0, 1, 1, 1};

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One reference move: best of seven tangent-octant neighbours.
    function automatic void ref_step(input arc_t a, inout int vx, inout int vy, inout int vz);
        int dx = vx - a.cx, dy = vy - a.cy, dz = vz - a.cz;
        int tx = a.ny * dz - a.nz * dy;
        int ty = a.nz * dx - a.nx * dz;
        int tz = a.nx * dy - a.ny * dx;
        int sx = (tx < 0) ? -1 : 1, sy = (ty < 0) ? -1 : 1, sz = (tz < 0) ? -1 : 1;
        longint best = -1;
        int bx = vx, by = vy, bz = vz;
        for (int k = 0; k < 7; k++) begin
            int px = vx + mk_x[k] * sx, py = vy + mk_y[k] * sy, pz = vz + mk_z[k] * sz;
            longint ex = px - a.cx, ey = py - a.cy, ez = pz - a.cz;
            longint re = ex * ex + ey * ey + ez * ez - a.r2;
            longint pe = a.nx * ex + a.ny * ey + a.nz * ez;
            longint s;
            if (re < 0) re = -re;
            if (pe < 0) pe = -pe;
            s = re + pe * a.w;
            if (best < 0 || s < best) begin
                best = s; bx = px; by = py; bz = pz;
            end
        end
        vx = bx; vy = by; vz = bz;
    endfunction

    // Voxel reached after k reference moves from the start.
    task automatic walk_to(input arc_t a, input int k, output int x, output int y, output int z);
        x = a.bx; y = a.by; z = a.bz;
        for (int i = 0; i < k; i++) ref_step(a, x, y, z);
    endtask

    // Cycle-level reference: 0 idle, 1 voxel offered, 2/3 the two work cycles.
    int m_st = 0, mx = 0, my = 0, mz = 0, m_steps = 0;
    bit m_done = 0, m_ovr = 0, cmp_en = 0;
    arc_t m_a;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_ovr = 0;
        end else begin
            case (m_st)
                0: if (arc_go) begin
                    m_a.cx = centre_x; m_a.cy = centre_y; m_a.cz = centre_z;
                    m_a.fx = last_x; m_a.fy = last_y; m_a.fz = last_z;
                    m_a.nx = norm_x; m_a.ny = norm_y; m_a.nz = norm_z;
                    m_a.r2 = radius_sq; m_a.w = plane_weight; m_a.lim = step_limit;
                    mx = first_x; my = first_y; mz = first_z;
                    m_steps = 0; m_done = 0; m_ovr = 0; m_st = 1;
                end
                1: if (vox_ready) begin
                    if (mx == m_a.fx && my == m_a.fy && mz == m_a.fz) begin
                        m_st = 0; m_done = 1;
                    end else if (m_steps == m_a.lim) begin
                        m_st = 0; m_done = 1; m_ovr = 1;
                    end else m_st = 2;
                end
                2: m_st = 3;
                default: begin
                    ref_step(m_a, mx, my, mz);
                    m_steps++; m_st = 1;
                end
            endcase
        end
    end

    // Compare every output against the reference on each clock.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(vox_valid == (m_st == 1), "R9", "valid", vox_valid, m_st == 1);
            if (m_st == 1) begin
                chk(vox_x == mx, "R2 R3 R8", "vox_x", vox_x, mx);
                chk(vox_y == my, "R2 R3 R8", "vox_y", vox_y, my);
                chk(vox_z == mz, "R2 R3 R8", "vox_z", vox_z, mz);
            end
            chk(busy == (m_st != 0), "R10", "busy", busy, m_st != 0);
            chk(done == m_done, "R6", "done", done, m_done);
            chk(overrun == m_ovr, "R7", "overrun", overrun, m_ovr);
        end
    end

    // Ready pattern: always high, or pseudo-random stalls.
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vox_ready <= (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
    end

    // Record the accepted voxels at the handshake edge.
    int px_q[$], py_q[$], pz_q[$];
    always @(posedge clk) begin
        if (rst_n && vox_valid && vox_ready) begin
            px_q.push_back(vox_x); py_q.push_back(vox_y); pz_q.push_back(vox_z);
        end
    end

    task automatic run_arc(input arc_t a, input int rm, input int exp_n,
                           input bit exp_ovr, input bit poke);
        int n = 0;
        int last_i;
        px_q.delete(); py_q.delete(); pz_q.delete();
        rmode = rm;
        @(negedge clk);
        centre_x = CW'(a.cx); centre_y = CW'(a.cy); centre_z = CW'(a.cz);
        first_x = CW'(a.bx); first_y = CW'(a.by); first_z = CW'(a.bz);
        last_x = CW'(a.fx); last_y = CW'(a.fy); last_z = CW'(a.fz);
        norm_x = NW'(a.nx); norm_y = NW'(a.ny); norm_z = NW'(a.nz);
        radius_sq = SQW'(a.r2); plane_weight = WW'(a.w); step_limit = LW'(a.lim);
        arc_go = 1;
        @(negedge clk);
        arc_go = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
                arc_go = 1;
                first_x = CW'(a.bx + 3); last_x = CW'(a.fx + 7); centre_y = CW'(a.cy - 2);
            end else arc_go = 0;
        end
        arc_go = 0;
        chk(done == 1'b1, "R6", "done after walk", done, 1);
        chk(overrun == exp_ovr, "R7", "overrun after walk", overrun, exp_ovr);
        chk(px_q.size() == exp_n, "R6 R7", "voxel count", px_q.size(), exp_n);
        if (px_q.size() > 0) begin
            last_i = px_q.size() - 1;
            chk(px_q[0] == a.bx && py_q[0] == a.by && pz_q[0] == a.bz, "R1", "first voxel x",
                px_q[0], a.bx);
            if (!exp_ovr)
                chk(px_q[last_i] == a.fx && py_q[last_i] == a.fy && pz_q[last_i] == a.fz,
                    "R6", "last voxel x", px_q[last_i], a.fx);
            for (int i = 1; i < px_q.size(); i++) begin
                int ax = px_q[i] - px_q[i-1], ay = py_q[i] - py_q[i-1], az = pz_q[i] - pz_q[i-1];
                bit ok = ax >= -1 && ax <= 1 && ay >= -1 && ay <= 1 && az >= -1 && az <= 1
                         && !(ax == 0 && ay == 0 && az == 0);
                chk(ok, "R5", "neighbour step index", i, i);
            end
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        arc_t a;
        int x, y, z;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(vox_valid == 0, "R11", "reset valid", vox_valid, 0);
        chk(busy == 0, "R11", "reset busy", busy, 0);
        chk(done == 0, "R11", "reset done", done, 0);
        chk(overrun == 0, "R11", "reset overrun", overrun, 0);
        cmp_en = 1;

        // Arc in the xy plane, ready always high.
        a = '{cx:0, cy:0, cz:0, bx:5, by:0, bz:0, fx:0, fy:0, fz:0,
              nx:0, ny:0, nz:1, r2:25, w:4, lim:1000};
        walk_to(a, 6, x, y, z); a.fx = x; a.fy = y; a.fz = z;
        run_arc(a, 0, 7, 0, 0);
        chk(px_q.size() > 1 && px_q[1] == 5 && py_q[1] == 1 && pz_q[1] == 0,
            "R2", "first move y", (py_q.size() > 1) ? py_q[1] : -99, 1);

        // Same arc, longer, with downstream stalls.
        walk_to(a, 10, x, y, z); a.fx = x; a.fy = y; a.fz = z;
        run_arc(a, 1, 11, 0, 0);

        // Tilted plane off the origin, with stalls.
        a = '{cx:10, cy:-5, cz:3, bx:13, by:-8, bz:7, fx:0, fy:0, fz:0,
              nx:1, ny:1, nz:0, r2:34, w:3, lim:1000};
        walk_to(a, 8, x, y, z); a.fx = x; a.fy = y; a.fz = z;
        run_arc(a, 1, 9, 0, 0);

        // Tie at a zero tangent: index 0 (+x) beats index 1 (+y).
        a = '{cx:0, cy:0, cz:0, bx:0, by:0, bz:0, fx:0, fy:0, fz:0,
              nx:0, ny:0, nz:1, r2:1, w:1, lim:1000};
        walk_to(a, 3, x, y, z); a.fx = x; a.fy = y; a.fz = z;
        run_arc(a, 0, 4, 0, 0);
        chk(px_q.size() > 1 && px_q[1] == 1 && py_q[1] == 0 && pz_q[1] == 0,
            "R4", "tie winner x", (px_q.size() > 1) ? px_q[1] : -99, 1);

        // Start equals end.
        a = '{cx:0, cy:0, cz:0, bx:2, by:2, bz:2, fx:2, fy:2, fz:2,
              nx:0, ny:0, nz:1, r2:8, w:2, lim:1000};
        run_arc(a, 0, 1, 0, 0);

        // Unreachable end: budget of five moves, then none.
        a = '{cx:0, cy:0, cz:0, bx:5, by:0, bz:0, fx:100, fy:100, fz:100,
              nx:0, ny:0, nz:1, r2:25, w:4, lim:5};
        run_arc(a, 1, 6, 1, 0);
        a.lim = 0;
        run_arc(a, 0, 1, 1, 0);

        // Go pulse with different set-up while busy.
        a = '{cx:0, cy:0, cz:0, bx:5, by:0, bz:0, fx:0, fy:0, fz:0,
              nx:0, ny:0, nz:1, r2:25, w:4, lim:1000};
        walk_to(a, 8, x, y, z); a.fx = x; a.fy = y; a.fz = z;
        run_arc(a, 1, 9, 0, 1);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule